// File: doc/BRIEF.md
# Two-Dimensional Parity Error Corrector

This block guards a small data matrix with one even-parity bit per row and one per column. The matrix is carried as a flat vector in which the bit in row r, column c sits at index r*COLS + c. An encode path turns a matrix into its row and column parity vectors. A separate decode path takes a received matrix with its received parity vectors and works out which row checks and which column checks fail. A single flipped data bit is repaired by inverting the bit where the one failing row meets the one failing column.

The decode path sorts each received word into one of four classes. The word is clean, or it has a correctable data error, or it has an error confined to a parity bit, or it has an error pattern that cannot be repaired. Both paths register their results and raise a valid strobe exactly one clock after their input strobe. The sizes are parameters, with a default of 4 rows by 8 columns.

Top module: `par2d_corrector`

## Requirements
- R1: One cycle after an encode strobe, enc_row_par[r] equals the XOR of data bits r*COLS through r*COLS+COLS-1, so each row and its parity bit hold an even number of ones.
- R2: One cycle after an encode strobe, enc_col_par[c] equals the XOR of data bits c, c+COLS, c+2*COLS and so on through every row.
- R3: enc_valid_out and dec_valid_out are high exactly in the cycle after enc_valid_in or dec_valid_in is high, and low otherwise. A synchronous active-high reset clears both valid outputs and all three decode flags.
- R4: On a decoded word, dec_row_syn[r] is the XOR of received row r and dec_row_par_in[r], and dec_col_syn[c] is the XOR of received column c and dec_col_par_in[c]. A 0 bit means that check passes.
- R5: When no check fails, dec_data_out equals the received data and dec_corrected, dec_par_err and dec_uncorr are all low.
- R6: When exactly one row check and exactly one column check fail, the data bit at their intersection is inverted, all other bits pass through unchanged, and dec_corrected is high.
- R7: When exactly one check fails on one side (row or column) and none fails on the other, the data passes unchanged and dec_par_err is high.
- R8: Any other syndrome pattern (two or more failing rows, or two or more failing columns) raises dec_uncorr and leaves the data unmodified. Two flips in the same row pass that row check and fail two column checks, so they fall in this class.
- R9: At most one of the three decode flags is high, and a flag is high only together with dec_valid_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_in | input | 1 | Encode request strobe |
| enc_data | input | ROWS*COLS | Matrix to encode, bit r*COLS+c is row r column c |
| enc_valid_out | output | 1 | Encode result strobe |
| enc_row_par | output | ROWS | Row parity bits |
| enc_col_par | output | COLS | Column parity bits |
| dec_valid_in | input | 1 | Decode request strobe |
| dec_data_in | input | ROWS*COLS | Received matrix |
| dec_row_par_in | input | ROWS | Received row parity bits |
| dec_col_par_in | input | COLS | Received column parity bits |
| dec_valid_out | output | 1 | Decode result strobe |
| dec_data_out | output | ROWS*COLS | Corrected or passed-through matrix |
| dec_row_syn | output | ROWS | Row check results, 1 means fail |
| dec_col_syn | output | COLS | Column check results, 1 means fail |
| dec_corrected | output | 1 | A single data bit was repaired |
| dec_par_err | output | 1 | Error lies in one parity bit |
| dec_uncorr | output | 1 | Pattern cannot be repaired |

## Verification
The hardest case to reach from the ports is a syndrome with exactly one failing row and exactly one failing column that comes from a data flip at a chosen position, rather than from two parity flips that imitate it. Purely random received words almost never land on it. The stimulus therefore encodes random matrices, then injects a chosen number of flips at random data or parity positions: zero, one data bit, one parity bit, two bits in one row, and two bits in distinct rows and columns. Each corner, such as index 0 and the last index, also gets a directed single-bit flip.

// File: rtl/par2d_pkg.sv
package par2d_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_FIX    = 2'd1,
    CLS_PARITY = 2'd2,
    CLS_BAD    = 2'd3
  } cls_e;

  // Sort a received word from the number of failing row and column checks.
  function automatic cls_e classify(input int unsigned n_row, input int unsigned n_col);
    cls_e res;
    if (n_row == 0 && n_col == 0)      res = CLS_CLEAN;
    else if (n_row == 1 && n_col == 1) res = CLS_FIX;
    else if ((n_row == 1 && n_col == 0) || (n_row == 0 && n_col == 1)) res = CLS_PARITY;
    else                               res = CLS_BAD;
    return res;
  endfunction

endpackage

// File: rtl/par2d_encoder.sv
module par2d_encoder #(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic [ROWS*COLS-1:0] data,
  output logic                 valid_out,
  output logic [ROWS-1:0]      row_par,
  output logic [COLS-1:0]      col_par
);
  localparam int NBITS = ROWS * COLS;

  logic [ROWS-1:0] row_par_c;
  logic [COLS-1:0] col_par_c;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_par_c[r] = ^data[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_pick
      assign col_bits[r] = data[r*COLS + c];
    end
    assign col_par_c[c] = ^col_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      row_par   <= '0;
      col_par   <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        row_par <= row_par_c;
        col_par <= col_par_c;
      end
    end
  end

  // Both vectors cover every data bit once, so their total parities agree.
  AST_ENC_TOTAL_AGREE: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> ((^row_par) == (^col_par))); // R1

  AST_ENC_ROW_EVEN: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> ((^{$past(data[NBITS-1 -: COLS]), row_par[ROWS-1]}) == 1'b0)); // R1

endmodule

// File: rtl/par2d_syndrome.sv
module par2d_syndrome #(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0]      data,
  input  logic [ROWS-1:0]           row_par,
  input  logic [COLS-1:0]           col_par,
  output logic [ROWS-1:0]           row_syn,
  output logic [COLS-1:0]           col_syn,
  output logic [$clog2(ROWS+1)-1:0] row_fails,
  output logic [$clog2(COLS+1)-1:0] col_fails
);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS + 1);

  function automatic logic [RW-1:0] count_rows(input logic [ROWS-1:0] v);
    logic [RW-1:0] n;
    n = '0;
    for (int i = 0; i < ROWS; i++) n = n + RW'(v[i]);
    return n;
  endfunction

  function automatic logic [CW-1:0] count_cols(input logic [COLS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < COLS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_syn[r] = (^data[r*COLS +: COLS]) ^ row_par[r];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_pick
      assign col_bits[r] = data[r*COLS + c];
    end
    assign col_syn[c] = (^col_bits) ^ col_par[c];
  end

  assign row_fails = count_rows(row_syn);
  assign col_fails = count_cols(col_syn);

endmodule

// File: rtl/par2d_fix.sv
module par2d_fix
  import par2d_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0]      data,
  input  logic [ROWS-1:0]           row_syn,
  input  logic [COLS-1:0]           col_syn,
  input  logic [$clog2(ROWS+1)-1:0] row_fails,
  input  logic [$clog2(COLS+1)-1:0] col_fails,
  output logic [ROWS*COLS-1:0]      data_fixed,
  output logic [ROWS*COLS-1:0]      flip_mask,
  output cls_e                      cls
);
  localparam int NBITS = ROWS * COLS;

  logic fix_en;

  assign cls    = classify(int'(row_fails), int'(col_fails));
  assign fix_en = (cls == CLS_FIX);

  // The mask bit at a crossing is set only when one row and one column fail.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign flip_mask[r*COLS + c] = fix_en & row_syn[r] & col_syn[c];
    end
  end

  assign data_fixed = data ^ flip_mask;

endmodule

// File: rtl/par2d_corrector.sv
module par2d_corrector
  import par2d_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enc_valid_in,
  input  logic [ROWS*COLS-1:0] enc_data,
  output logic                 enc_valid_out,
  output logic [ROWS-1:0]      enc_row_par,
  output logic [COLS-1:0]      enc_col_par,
  input  logic                 dec_valid_in,
  input  logic [ROWS*COLS-1:0] dec_data_in,
  input  logic [ROWS-1:0]      dec_row_par_in,
  input  logic [COLS-1:0]      dec_col_par_in,
  output logic                 dec_valid_out,
  output logic [ROWS*COLS-1:0] dec_data_out,
  output logic [ROWS-1:0]      dec_row_syn,
  output logic [COLS-1:0]      dec_col_syn,
  output logic                 dec_corrected,
  output logic                 dec_par_err,
  output logic                 dec_uncorr
);
  localparam int NBITS = ROWS * COLS;
  localparam int RW    = $clog2(ROWS + 1);
  localparam int CW    = $clog2(COLS + 1);

  logic [ROWS-1:0]  syn_row;
  logic [COLS-1:0]  syn_col;
  logic [RW-1:0]    fails_row;
  logic [CW-1:0]    fails_col;
  logic [NBITS-1:0] fixed_data;
  logic [NBITS-1:0] flip_mask;
  cls_e             word_cls;

  par2d_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (enc_valid_in),
    .data      (enc_data),
    .valid_out (enc_valid_out),
    .row_par   (enc_row_par),
    .col_par   (enc_col_par)
  );

  par2d_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .data      (dec_data_in),
    .row_par   (dec_row_par_in),
    .col_par   (dec_col_par_in),
    .row_syn   (syn_row),
    .col_syn   (syn_col),
    .row_fails (fails_row),
    .col_fails (fails_col)
  );

  par2d_fix #(.ROWS(ROWS), .COLS(COLS)) u_fix (
    .data       (dec_data_in),
    .row_syn    (syn_row),
    .col_syn    (syn_col),
    .row_fails  (fails_row),
    .col_fails  (fails_col),
    .data_fixed (fixed_data),
    .flip_mask  (flip_mask),
    .cls        (word_cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_out <= 1'b0;
      dec_corrected <= 1'b0;
      dec_par_err   <= 1'b0;
      dec_uncorr    <= 1'b0;
      dec_data_out  <= '0;
      dec_row_syn   <= '0;
      dec_col_syn   <= '0;
    end else begin
      dec_valid_out <= dec_valid_in;
      dec_corrected <= dec_valid_in && (word_cls == CLS_FIX);
      dec_par_err   <= dec_valid_in && (word_cls == CLS_PARITY);
      dec_uncorr    <= dec_valid_in && (word_cls == CLS_BAD);
      if (dec_valid_in) begin
        dec_data_out <= fixed_data;
        dec_row_syn  <= syn_row;
        dec_col_syn  <= syn_col;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    dec_valid_in |=> dec_valid_out); // R3

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_in |=> !dec_valid_out); // R3

  AST_ENC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    enc_valid_in |=> enc_valid_out); // R3

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_corrected, dec_par_err, dec_uncorr})); // R9

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (dec_corrected || dec_par_err || dec_uncorr) |-> dec_valid_out); // R9

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_out && dec_row_syn == '0 && dec_col_syn == '0)
      |-> (!dec_corrected && !dec_par_err && !dec_uncorr)); // R5

  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    dec_valid_in |=> (dec_corrected ? ($countones(dec_data_out ^ $past(dec_data_in)) == 1)
                                    : (dec_data_out == $past(dec_data_in)))); // R6

  AST_FIX_SYNDROME: assert property (@(posedge clk) disable iff (rst)
    dec_corrected |-> ($countones(dec_row_syn) == 1 && $countones(dec_col_syn) == 1)); // R6

  AST_PARITY_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    dec_par_err |-> ($countones({dec_row_syn, dec_col_syn}) == 1)); // R7

  AST_BAD_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    dec_valid_in && (word_cls == CLS_BAD) |=> (dec_uncorr && dec_data_out == $past(dec_data_in))); // R8

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flip_mask)); // R6

endmodule

// File: tb/sim_par2d_corrector.sv
module sim_par2d_corrector;
  localparam int R = 4;
  localparam int C = 8;
  localparam int N = R * C;

  logic         clk = 1'b0;
  logic         rst;
  logic         enc_valid_in;
  logic [N-1:0] enc_data;
  logic         enc_valid_out;
  logic [R-1:0] enc_row_par;
  logic [C-1:0] enc_col_par;
  logic         dec_valid_in;
  logic [N-1:0] dec_data_in;
  logic [R-1:0] dec_row_par_in;
  logic [C-1:0] dec_col_par_in;
  logic         dec_valid_out;
  logic [N-1:0] dec_data_out;
  logic [R-1:0] dec_row_syn;
  logic [C-1:0] dec_col_syn;
  logic         dec_corrected;
  logic         dec_par_err;
  logic         dec_uncorr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  par2d_corrector #(.ROWS(R), .COLS(C)) u0 (
    .clk(clk), .rst(rst),
    .enc_valid_in(enc_valid_in), .enc_data(enc_data),
    .enc_valid_out(enc_valid_out), .enc_row_par(enc_row_par), .enc_col_par(enc_col_par),
    .dec_valid_in(dec_valid_in), .dec_data_in(dec_data_in),
    .dec_row_par_in(dec_row_par_in), .dec_col_par_in(dec_col_par_in),
    .dec_valid_out(dec_valid_out), .dec_data_out(dec_data_out),
    .dec_row_syn(dec_row_syn), .dec_col_syn(dec_col_syn),
    .dec_corrected(dec_corrected), .dec_par_err(dec_par_err), .dec_uncorr(dec_uncorr)
  );

  function automatic logic [R-1:0] ref_rows(input logic [N-1:0] d);
    logic [R-1:0] p = '0;
    for (int i = 0; i < N; i++) p[i / C] = p[i / C] ^ d[i];
    return p;
  endfunction

  function automatic logic [C-1:0] ref_cols(input logic [N-1:0] d);
    logic [C-1:0] p = '0;
    for (int i = 0; i < N; i++) p[i % C] = p[i % C] ^ d[i];
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic encode(input logic [N-1:0] d);
    @(negedge clk);
    enc_data = d;
    enc_valid_in = 1'b1;
    @(posedge clk);
    #1;
    enc_valid_in = 1'b0;
    check("R3 enc valid", 64'(enc_valid_out), 64'd1);
    check("R1 row parity", 64'(enc_row_par), 64'(ref_rows(d)));
    check("R2 col parity", 64'(enc_col_par), 64'(ref_cols(d)));
    @(posedge clk);
    #1;
    check("R3 enc valid drop", 64'(enc_valid_out), 64'd0);
  endtask

  // Decode a received word and compare against a reference worked out here.
  task automatic decode(input logic [N-1:0] d, input logic [R-1:0] rp, input logic [C-1:0] cp);
    logic [R-1:0] rs;
    logic [C-1:0] cs;
    int nr, nc, fr, fc;
    logic [N-1:0] ed;
    logic ecor, epar, ebad;
    string tag;
    rs = ref_rows(d) ^ rp;
    cs = ref_cols(d) ^ cp;
    nr = 0; nc = 0; fr = 0; fc = 0;
    for (int i = 0; i < R; i++) if (rs[i]) begin nr++; fr = i; end
    for (int i = 0; i < C; i++) if (cs[i]) begin nc++; fc = i; end
    ed = d; ecor = 0; epar = 0; ebad = 0;
    if (nr == 0 && nc == 0) tag = "R5";
    else if (nr == 1 && nc == 1) begin ed[fr*C + fc] = ~d[fr*C + fc]; ecor = 1; tag = "R6"; end
    else if (nr + nc == 1) begin epar = 1; tag = "R7"; end
    else begin ebad = 1; tag = "R8"; end
    @(negedge clk);
    dec_data_in = d;
    dec_row_par_in = rp;
    dec_col_par_in = cp;
    dec_valid_in = 1'b1;
    @(posedge clk);
    #1;
    dec_valid_in = 1'b0;
    check("R3 dec valid", 64'(dec_valid_out), 64'd1);
    check("R4 row syndrome", 64'(dec_row_syn), 64'(rs));
    check("R4 col syndrome", 64'(dec_col_syn), 64'(cs));
    check({tag, " data"}, 64'(dec_data_out), 64'(ed));
    check({tag, " flags"}, 64'({dec_corrected, dec_par_err, dec_uncorr}), 64'({ecor, epar, ebad}));
    @(posedge clk);
    #1;
    check("R9 flags idle", 64'({dec_valid_out, dec_corrected, dec_par_err, dec_uncorr}), 64'd0);
  endtask

  task automatic send(input logic [N-1:0] d, input logic [R-1:0] rf, input logic [C-1:0] cf,
                      input logic [N-1:0] df);
    decode(d ^ df, ref_rows(d) ^ rf, ref_cols(d) ^ cf);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    int a, b;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    enc_valid_in = 0; enc_data = '0;
    dec_valid_in = 0; dec_data_in = '0; dec_row_par_in = '0; dec_col_par_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset state", 64'({enc_valid_out, dec_valid_out, dec_corrected, dec_par_err, dec_uncorr}), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // Directed corners.
    encode('0);
    encode('1);
    encode(32'h8000_0001);
    send('0, '0, '0, '0);                       // R5 clean zero
    send('1, '0, '0, 32'h0000_0001);            // R6 first bit
    send('0, '0, '0, 32'h8000_0000);            // R6 last bit
    send(32'hA5A5_5A5A, 4'b0001, '0, '0);       // R7 row parity bit
    send(32'hA5A5_5A5A, '0, 8'h80, '0);         // R7 column parity bit
    send(32'h1234_5678, '0, '0, 32'h0000_0011); // R8 two flips same row
    send(32'h1234_5678, '0, '0, 32'h0000_0201); // R8 two rows two columns
    send(32'h1234_5678, 4'b0011, '0, '0);       // R8 two row parity bits

    // Random matrices with injected error patterns.
    for (int k = 0; k < 300; k++) begin
      d = {$urandom(), $urandom()} % (64'd1 << N);
      encode(d);
      a = $urandom_range(N - 1);
      b = $urandom_range(N - 1);
      case (k % 6)
        0: send(d, '0, '0, '0);
        1: send(d, '0, '0, N'(1) << a);
        2: send(d, R'(1) << (a % R), '0, '0);
        3: send(d, '0, C'(1) << (a % C), '0);
        4: send(d, '0, '0, (N'(1) << a) | (N'(1) << ((a / C) * C + ((a % C + 1 + b % (C - 1)) % C))));
        default: send(d, R'($urandom()), C'($urandom()), N'($urandom()));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule